// File: doc/BRIEF.md
# Linear Page Table Walker

This block resolves a translation miss by reading one entry from a single-level linear page table in memory. When a virtual address and a table base are presented on the request port, the walker takes the page number from the address, forms the entry address, and issues a single memory read over a valid/ready request channel. It then waits for the response for as many cycles as memory needs.

When the entry returns, the walker decodes it. A valid entry produces a physical address and its permission bits, and a fill record for the translation cache is emitted in the same cycle. An entry marked not present raises a page fault instead, and no fill record is produced. Only one walk is in flight at a time. New requests are taken only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: reqReady is 1, busy is 0, and memReqValid, doneValid, fillValid and pageFault are 0.
- R2: The page number is the virtual address shifted right by 12 (4 KB pages). In the cycle after a request is accepted, memReqValid rises with memReqAddr equal to ptBase + pageNumber * 8, taken modulo 2^MEM_AW.
- R3: While memReqValid is high and memReqReady is low, memReqValid stays high and memReqAddr does not change.
- R4: busy rises in the cycle after acceptance and stays high through the result cycle. reqReady is the inverse of busy. reqValid, reqVa and ptBase are ignored while busy, and the result uses the values captured at acceptance.
- R5: The walker waits any number of cycles for memRspValid. doneValid is high for exactly one cycle, namely the cycle after the response is taken. In that cycle donePa equals entry bits 51:12 concatenated with virtual address bits 11:0.
- R6: In the result cycle donePerm equals entry bits 3:1, with bit 3 = read, bit 2 = write and bit 1 = execute. Entry bits 63:52 and 11:4 have no effect on any output.
- R7: When entry bit 0 (valid) is 1, fillValid is high in the result cycle, with fillVpn equal to the captured page number and fillPfn equal to entry bits 51:12.
- R8: When entry bit 0 is 0, pageFault is high in the result cycle and fillValid stays low. Outside the result cycle, fillValid and pageFault are both low.
- R9: Each walk issues exactly one memory request. memReqValid drops in the cycle after the handshake and stays low until the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVa | input | VA_W | Virtual address that missed |
| ptBase | input | MEM_AW | Page table base address |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | MEM_AW | Entry byte address |
| memRspValid | input | 1 | Entry data returned |
| memRspData | input | 64 | Entry contents |
| doneValid | output | 1 | Result cycle |
| donePa | output | OFF_W+PFN_W | Physical address |
| donePerm | output | 3 | Read/write/execute bits |
| pageFault | output | 1 | Entry not present |
| fillValid | output | 1 | Write translation into cache |
| fillVpn | output | VA_W-OFF_W | Page number for the fill |
| fillPfn | output | PFN_W | Frame number for the fill |

## Verification
The assertions assume that memory raises memRspValid only while the walker is waiting for the entry it requested, and that each read gets exactly one response. The stimulus keeps to this: it returns exactly one response per granted read, after a chosen delay, and never drives a stray response. The stimulus also covers the other cases the requirements name: memReqReady held low for many cycles, slow responses, requests kept asserted with changing addresses during a walk, back-to-back walks, the top page number with a base that makes the address carry, and entries with junk in the ignored bits.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    PTW_IDLE  = 2'd0,
    PTW_ISSUE = 2'd1,
    PTW_WAIT  = 2'd2,
    PTW_DONE  = 2'd3
  } ptwState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;  // latch address and compute entry address
    logic capPte;  // latch returned entry
  } ptwStrobe_t;

  localparam int PTE_W        = 64;
  localparam int PTE_VALID    = 0;
  localparam int PTE_PERM_LO  = 1;
  localparam int PTE_PERM_W   = 3;

endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import pt_walker_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int OFF_W      = 12,
  parameter int PFN_W      = 40,
  parameter int MEM_AW     = 52,
  parameter int ENTRY_LOG2 = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ptwStrobe_t             strobe,
  input  logic [VA_W-1:0]        reqVa,
  input  logic [MEM_AW-1:0]      ptBase,
  input  logic [PTE_W-1:0]       memRspData,
  output logic [MEM_AW-1:0]      memReqAddr,
  output logic [OFF_W+PFN_W-1:0] donePa,
  output logic [PTE_PERM_W-1:0]  donePerm,
  output logic                   pteValid,
  output logic [VA_W-OFF_W-1:0]  fillVpn,
  output logic [PFN_W-1:0]       fillPfn
);

  localparam int VPN_W = VA_W - OFF_W;

  logic [VA_W-1:0]   vaReg;
  logic [MEM_AW-1:0] addrReg;
  logic [PTE_W-1:0]  pteReg;
  logic [VPN_W-1:0]  vpnIn;
  logic [MEM_AW-1:0] entryOffset;

  assign vpnIn       = reqVa[VA_W-1:OFF_W];
  assign entryOffset = MEM_AW'(vpnIn) << ENTRY_LOG2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaReg   <= '0;
      addrReg <= '0;
      pteReg  <= '0;
    end else begin
      if (strobe.capReq) begin
        vaReg   <= reqVa;
        addrReg <= ptBase + entryOffset;
      end
      if (strobe.capPte) begin
        pteReg <= memRspData;
      end
    end
  end

  assign memReqAddr = addrReg;
  assign fillPfn    = pteReg[OFF_W+PFN_W-1:OFF_W];
  assign fillVpn    = vaReg[VA_W-1:OFF_W];
  assign donePa     = {fillPfn, vaReg[OFF_W-1:0]};
  assign donePerm   = pteReg[PTE_PERM_LO+PTE_PERM_W-1:PTE_PERM_LO];
  assign pteValid   = pteReg[PTE_VALID];

endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import pt_walker_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       pteValid,
  output logic       reqReady,
  output logic       busy,
  output logic       memReqValid,
  output logic       doneValid,
  output logic       fillValid,
  output logic       pageFault,
  output ptwStrobe_t strobe
);

  ptwState_e state, stateNext;

  always_comb begin
    stateNext     = state;
    strobe.capReq = 1'b0;
    strobe.capPte = 1'b0;
    unique case (state)
      PTW_IDLE: begin
        if (reqValid) begin
          strobe.capReq = 1'b1;
          stateNext     = PTW_ISSUE;
        end
      end
      PTW_ISSUE: begin
        if (memReqReady) stateNext = PTW_WAIT;
      end
      PTW_WAIT: begin
        if (memRspValid) begin
          strobe.capPte = 1'b1;
          stateNext     = PTW_DONE;
        end
      end
      PTW_DONE: stateNext = PTW_IDLE;
      default:  stateNext = PTW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PTW_IDLE;
    else        state <= stateNext;
  end

  assign reqReady    = (state == PTW_IDLE);
  assign busy        = (state != PTW_IDLE);
  assign memReqValid = (state == PTW_ISSUE);
  assign doneValid   = (state == PTW_DONE);
  assign fillValid   = doneValid && pteValid;
  assign pageFault   = doneValid && !pteValid;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int OFF_W      = 12,
  parameter int PFN_W      = 40,
  parameter int MEM_AW     = 52,
  parameter int ENTRY_LOG2 = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [VA_W-1:0]        reqVa,
  input  logic [MEM_AW-1:0]      ptBase,
  output logic                   busy,
  output logic                   memReqValid,
  input  logic                   memReqReady,
  output logic [MEM_AW-1:0]      memReqAddr,
  input  logic                   memRspValid,
  input  logic [63:0]            memRspData,
  output logic                   doneValid,
  output logic [OFF_W+PFN_W-1:0] donePa,
  output logic [2:0]             donePerm,
  output logic                   pageFault,
  output logic                   fillValid,
  output logic [VA_W-OFF_W-1:0]  fillVpn,
  output logic [PFN_W-1:0]       fillPfn
);

  ptwStrobe_t strobe;
  logic       pteValid;

  ptw_control u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .pteValid    (pteValid),
    .reqReady    (reqReady),
    .busy        (busy),
    .memReqValid (memReqValid),
    .doneValid   (doneValid),
    .fillValid   (fillValid),
    .pageFault   (pageFault),
    .strobe      (strobe)
  );

  ptw_datapath #(
    .VA_W       (VA_W),
    .OFF_W      (OFF_W),
    .PFN_W      (PFN_W),
    .MEM_AW     (MEM_AW),
    .ENTRY_LOG2 (ENTRY_LOG2)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .reqVa      (reqVa),
    .ptBase     (ptBase),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .donePa     (donePa),
    .donePerm   (donePerm),
    .pteValid   (pteValid),
    .fillVpn    (fillVpn),
    .fillPfn    (fillPfn)
  );

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int MEM_AW = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic              busy,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [MEM_AW-1:0] memReqAddr,
  input logic              doneValid,
  input logic              fillValid,
  input logic              pageFault
);

  assert_accept_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> memReqValid);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> busy && !reqReady);

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !doneValid |=> busy);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);

  assert_fill_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid |-> doneValid);

  assert_fill_or_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> $countones({fillValid, pageFault}) == 1);

  assert_single_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && memReqReady |=> !memReqValid);

endmodule

bind pt_walker ptw_checker #(.MEM_AW(MEM_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .busy        (busy),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .doneValid   (doneValid),
  .fillValid   (fillValid),
  .pageFault   (pageFault)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic [51:0] ptBase = '0;
  logic        memReqReady = 1'b0;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        reqReady, busy, memReqValid, doneValid, pageFault, fillValid;
  logic [51:0] memReqAddr, donePa;
  logic [2:0]  donePerm;
  logic [19:0] fillVpn;
  logic [39:0] fillPfn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  int          phase = 0;  // 0 idle, 1 request out, 2 awaiting data, 3 result
  logic [31:0] mVa;
  logic [51:0] mAddr;
  logic [63:0] mPte;

  always #4 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .ptBase(ptBase), .busy(busy), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .doneValid(doneValid), .donePa(donePa),
    .donePerm(donePerm), .pageFault(pageFault), .fillValid(fillValid),
    .fillVpn(fillVpn), .fillPfn(fillPfn)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R4 reqReady", 64'(reqReady), 64'(phase == 0));
    chk("R4 busy", 64'(busy), 64'(phase != 0));
    chk("R9 memReqValid", 64'(memReqValid), 64'(phase == 1));
    if (phase == 1) chk("R2 memReqAddr", 64'(memReqAddr), 64'(mAddr));
    chk("R5 doneValid", 64'(doneValid), 64'(phase == 3));
    if (phase == 3) begin
      chk("R5 donePa", 64'(donePa), 64'({mPte[51:12], mVa[11:0]}));
      chk("R6 donePerm", 64'(donePerm), 64'(mPte[3:1]));
      chk("R7 fillValid", 64'(fillValid), 64'(mPte[0]));
      chk("R8 pageFault", 64'(pageFault), 64'(!mPte[0]));
      if (mPte[0]) begin
        chk("R7 fillVpn", 64'(fillVpn), 64'(mVa[31:12]));
        chk("R7 fillPfn", 64'(fillPfn), 64'(mPte[51:12]));
      end
    end else begin
      chk("R8 no fill", 64'(fillValid), 64'(0));
      chk("R8 no fault", 64'(pageFault), 64'(0));
    end
  endtask

  // one clock: DUT and model advance on the same inputs, compared at negedge
  task automatic tick();
    @(posedge clk);
    case (phase)
      0: if (reqValid) begin
           mVa   = reqVa;
           mAddr = ptBase + (52'(reqVa >> 12) << 3);
           phase = 1;
         end
      1: if (memReqReady) phase = 2;
      2: if (memRspValid) begin
           mPte  = memRspData;
           phase = 3;
         end
      default: phase = 0;
    endcase
    @(negedge clk);
    compare();
  endtask

  task automatic walk(input logic [31:0] va, input logic [51:0] base,
                      input logic [63:0] pte, input int grantDelay,
                      input int rspDelay, input bit holdReq);
    reqValid = 1'b1;
    reqVa    = va;
    ptBase   = base;
    tick();
    if (holdReq) begin
      reqVa  = ~va;        // R4: must be ignored while busy
      ptBase = base ^ 52'hABCDE;
    end else begin
      reqValid = 1'b0;
    end
    for (int i = 0; i < grantDelay; i++) begin
      tick();
      if (holdReq) reqVa = reqVa + 32'h1000;
    end
    memReqReady = 1'b1;
    tick();
    memReqReady = 1'b0;
    for (int i = 0; i < rspDelay; i++) tick();
    memRspValid = 1'b1;
    memRspData  = pte;
    tick();
    memRspValid = 1'b0;
    memRspData  = {64{1'b1}};
    reqValid    = 1'b0;
    tick();               // back to idle
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 reqReady", 64'(reqReady), 64'(1));
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 memReqValid", 64'(memReqValid), 64'(0));
    chk("R1 doneValid", 64'(doneValid), 64'(0));
    chk("R1 fillValid", 64'(fillValid), 64'(0));
    chk("R1 pageFault", 64'(pageFault), 64'(0));
    tick();
    // basic valid walk, rwx set
    walk(32'h0000_1444, 52'h0_0000_2000, 64'h0000_0000_0000_500F, 0, 0, 0);
    // R6: junk in ignored bits 63:52 and 11:4
    walk(32'h0ABC_D123, 52'h0_1234_5000, 64'hFFF0_0012_3456_7FF5, 2, 3, 0);
    // R8: entry not present
    walk(32'h7000_0FFF, 52'h0_0000_8000, 64'h0000_0000_0004_000E, 0, 1, 0);
    // R3 R5: long grant wait and slow response
    walk(32'h0000_2004, 52'h0_0000_0008, 64'h000F_FFFF_FFFF_F003, 40, 60, 0);
    // R4: request held and address changing during walk
    walk(32'h1234_5678, 52'h0_0001_0000, 64'h0000_0ABC_DEF0_1009, 5, 4, 1);
    // R2: top page number with base forcing carry and wrap
    walk(32'hFFFF_F000, 52'hF_FFFF_FFFF_FFF8, 64'h0000_0000_0000_1001, 1, 0, 0);
    // back-to-back walks, mixed outcomes
    for (int k = 0; k < 8; k++) begin
      walk(32'h0040_0000 + 32'(k) * 32'h0001_1010, 52'h0_0000_4000 + 52'(k * 8),
           {24'h0, 20'(k * 977), 8'h00, 4'h0, 4'(k * 3)}, k % 3, (k * 5) % 7, k[0]);
    end
    tick();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R5 watchdog: actual=hung expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule